// File: doc/BRIEF.md
# Trigger-Matched Readout Sequencer

This block is the chip-level controller that paces trigger-matched readout of a pixel matrix. Every trigger pulse gets a 4-bit identifier and is stamped with the value of a free-running 24-bit bunch-crossing counter. The sequencer serves one identifier at a time. It first waits until some pixel region on the token chain raises its token. It then drives a single global read strobe for as long as any region still holds a token.

Two of its waiting states are gated by a small delay counter and by a ready flag from the downstream output FIFO, so readout never starts sooner than the chain can settle or faster than the FIFO can absorb. When the token chain empties and a newer trigger has already been recorded, the sequencer goes straight back to waiting for tokens for that trigger and does not pass through idle.

Top module: `trig_readout_ctrl`

## Requirements
- R1: After reset `read_o` is 0, `req_id_o` and `latest_id_o` are 0, `latest_bc_o` is 0, and the sequencer is idle.
- R2: In idle, a trigger pulse, or an outstanding trigger (`latest_id_o` differs from `req_id_o`), moves the sequencer into the token-wait phase. `req_id_o` steps by one on that same edge and `read_o` stays 0.
- R3: The token-wait phase clears its delay counter on entry and is left only when the counter has reached 2 and `token_i` and `fifo_rdy_i` are both 1. When both inputs are already high, `read_o` rises on the third clock edge after the edge that samples the trigger. With `token_i` low, `read_o` stays 0.
- R4: The read-start phase also clears the delay counter on entry. It holds `read_o` at 1 and ignores `token_i`, and it moves on to the read phase only when the counter is 2 and `fifo_rdy_i` is 1.
- R5: In the read phase `read_o` stays 1 and `req_id_o` stays unchanged while `token_i` is 1, even when new triggers arrive.
- R6: When `token_i` is 0 in the read phase and `latest_id_o` differs from `req_id_o`, the next edge drops `read_o`, steps `req_id_o` by one and re-enters token wait. `read_o` rises again three edges later if the token and FIFO-ready inputs are high.
- R7: When `token_i` is 0 in the read phase and the identifiers are equal, the sequencer returns to idle with `read_o` at 0. A token alone does not restart it.
- R8: `latest_id_o` steps by one, modulo 16, on every edge that samples `trig_i` high, whatever the sequencer state.
- R9: On each trigger, `latest_bc_o` captures the bunch-crossing counter. The counter is 0 during reset and increases by one on every clock edge after reset.
- R10: `req_bc_o` shows the timestamp stored for `req_id_o`, one cycle after `req_id_o` changes.
- R11: While `fifo_rdy_i` is 0, the token-wait phase holds and `read_o` stays 0 however long the wait lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse, one per trigger per cycle |
| token_i | input | 1 | Some region on the chain holds a token |
| fifo_rdy_i | input | 1 | Output FIFO can accept data |
| read_o | output | 1 | Global read strobe to the regions |
| req_id_o | output | 4 | Identifier of the trigger being served |
| latest_id_o | output | 4 | Identifier of the most recent trigger |
| latest_bc_o | output | 24 | Bunch-crossing stamp of the most recent trigger |
| req_bc_o | output | 24 | Bunch-crossing stamp of the served trigger |

## Verification
The sequencer is driven in four ways, and each one separates a different exit rule. In the first, token and FIFO-ready are both high from the start, which pins the exact three-edge delay of each gated phase. In the second, FIFO-ready is held low, which shows that both gated phases wait for it and that read-start ignores a dropped token. In the third, a second trigger arrives during the read phase, which separates the direct return to token wait from the return to idle and checks that the served timestamp follows the new identifier. In the fourth, sixteen back-to-back triggers arrive with no token, which checks identifier wraparound and that read stays low without a token.

// File: rtl/trig_readout_pkg.sv
package trig_readout_pkg;
  localparam int ID_W_DEF  = 4;
  localparam int BC_W_DEF  = 24;
  localparam int DLY_LIM_DEF = 2;

  typedef enum logic [1:0] {
    ST_TRIG_WAIT = 2'd0,
    ST_TOK_START = 2'd1,
    ST_RD_START  = 2'd2,
    ST_RD_RUN    = 2'd3
  } rd_state_e;
endpackage

// File: rtl/trig_stamp_store.sv
module trig_stamp_store #(
  parameter int ID_W = 4,
  parameter int BC_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic [ID_W-1:0] req_id_i,
  output logic [ID_W-1:0] latest_id_o,
  output logic [BC_W-1:0] latest_bc_o,
  output logic [BC_W-1:0] req_bc_o
);
  localparam int DEPTH = 1 << ID_W;

  logic [BC_W-1:0] bc_q;
  logic [ID_W-1:0] latest_q;
  logic [BC_W-1:0] stamp_q;
  logic [BC_W-1:0] rd_q;
  logic [BC_W-1:0] ts_mem [DEPTH];

  // free-running bunch-crossing counter
  always_ff @(posedge clk) begin
    if (rst) bc_q <= '0;
    else     bc_q <= bc_q + BC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latest_q <= '0;
      stamp_q  <= '0;
    end else if (trig_i) begin
      latest_q <= latest_q + ID_W'(1);
      stamp_q  <= bc_q;
    end
  end

  // stamp memory: one write port, registered read (RAM-inferable)
  always_ff @(posedge clk) begin
    if (trig_i) ts_mem[latest_q + ID_W'(1)] <= bc_q;
  end

  always_ff @(posedge clk) begin
    rd_q <= ts_mem[req_id_i];
  end

  assign latest_id_o = latest_q;
  assign latest_bc_o = stamp_q;
  assign req_bc_o    = rd_q;

  a_r8_latest_step: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> latest_q == $past(latest_q) + ID_W'(1));

  a_r8_latest_hold: assert property (@(posedge clk) disable iff (rst)
    !trig_i |=> $stable(latest_q));

  a_r9_bc_count: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bc_q == $past(bc_q) + BC_W'(1));

  a_r9_stamp_capture: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> stamp_q == $past(bc_q));
endmodule

// File: rtl/readout_seq_fsm.sv
module readout_seq_fsm
  import trig_readout_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int DLY_LIM = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic            token_i,
  input  logic            fifo_rdy_i,
  input  logic [ID_W-1:0] latest_id_i,
  output logic            read_o,
  output logic [ID_W-1:0] req_id_o
);
  localparam int DLY_W = $clog2(DLY_LIM + 1);

  rd_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic [ID_W-1:0] req_q;
  logic            read_q;
  logic            adv_req;
  logic            dly_done;
  logic            pending;

  assign dly_done = (dly_q == DLY_W'(DLY_LIM));
  assign pending  = (latest_id_i != req_q);

  always_comb begin
    state_d = state_q;
    adv_req = 1'b0;
    case (state_q)
      ST_TRIG_WAIT: if (trig_i || pending) begin
        state_d = ST_TOK_START;
        adv_req = 1'b1;
      end
      ST_TOK_START: if (dly_done && fifo_rdy_i && token_i) state_d = ST_RD_START;
      ST_RD_START:  if (dly_done && fifo_rdy_i) state_d = ST_RD_RUN;
      ST_RD_RUN: if (!token_i) begin
        if (pending) begin
          state_d = ST_TOK_START;
          adv_req = 1'b1;
        end else begin
          state_d = ST_TRIG_WAIT;
        end
      end
      default: state_d = ST_TRIG_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_TRIG_WAIT;
      dly_q   <= '0;
      req_q   <= '0;
      read_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      read_q  <= (state_d == ST_RD_START) || (state_d == ST_RD_RUN);
      if (adv_req) req_q <= req_q + ID_W'(1);
      if (state_d != state_q)  dly_q <= '0;
      else if (!dly_done)      dly_q <= dly_q + DLY_W'(1);
    end
  end

  assign read_o   = read_q;
  assign req_id_o = req_q;

  a_r3_rise_needs_token: assert property (@(posedge clk) disable iff (rst)
    $rose(read_q) |-> ($past(token_i) && $past(fifo_rdy_i)));

  a_r3_start_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TOK_START && !dly_done) |=> state_q == ST_TOK_START);

  a_r4_rdstart_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_START && !fifo_rdy_i) |=> (state_q == ST_RD_START && read_q));

  a_r5_read_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_RUN && token_i) |=> (read_q && $stable(req_q)));

  a_r6_req_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(req_q) |-> (state_q == ST_TOK_START && req_q == $past(req_q) + ID_W'(1)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TRIG_WAIT) |-> !read_q);

  a_r11_fifo_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TOK_START && !fifo_rdy_i) |=> !read_q);
endmodule

// File: rtl/trig_readout_ctrl.sv
module trig_readout_ctrl
  import trig_readout_pkg::*;
#(
  parameter int ID_W    = ID_W_DEF,
  parameter int BC_W    = BC_W_DEF,
  parameter int DLY_LIM = DLY_LIM_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic            token_i,
  input  logic            fifo_rdy_i,
  output logic            read_o,
  output logic [ID_W-1:0] req_id_o,
  output logic [ID_W-1:0] latest_id_o,
  output logic [BC_W-1:0] latest_bc_o,
  output logic [BC_W-1:0] req_bc_o
);
  logic [ID_W-1:0] latest_id;
  logic [ID_W-1:0] req_id;

  trig_stamp_store #(.ID_W(ID_W), .BC_W(BC_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig_i),
    .req_id_i   (req_id),
    .latest_id_o(latest_id),
    .latest_bc_o(latest_bc_o),
    .req_bc_o   (req_bc_o)
  );

  readout_seq_fsm #(.ID_W(ID_W), .DLY_LIM(DLY_LIM)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig_i),
    .token_i    (token_i),
    .fifo_rdy_i (fifo_rdy_i),
    .latest_id_i(latest_id),
    .read_o     (read_o),
    .req_id_o   (req_id)
  );

  assign req_id_o    = req_id;
  assign latest_id_o = latest_id;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!read_o && req_id_o == '0 && latest_id_o == '0 && latest_bc_o == '0));
endmodule

// File: tb/trig_readout_ctrl_bench.sv
module trig_readout_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic        token = 1'b0;
  logic        rdy = 1'b0;
  logic        read;
  logic [3:0]  req_id, latest_id;
  logic [23:0] latest_bc, req_bc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [23:0] cyc = '0;

  always #10 clk = ~clk;

  // expected bunch-crossing count (R9): 0 in reset, +1 per edge after
  always @(posedge clk) cyc <= rst ? 24'd0 : cyc + 24'd1;

  trig_readout_ctrl u_trig_readout_ctrl (
    .clk(clk), .rst(rst), .trig_i(trig), .token_i(token), .fifo_rdy_i(rdy),
    .read_o(read), .req_id_o(req_id), .latest_id_o(latest_id),
    .latest_bc_o(latest_bc), .req_bc_o(req_bc)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_trig(output logic [23:0] bc);
    bc = cyc;
    trig = 1'b1;
    step(1);
    trig = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 read after reset", read, 0);
    check("R1 req_id after reset", req_id, 0);
    check("R1 latest_id after reset", latest_id, 0);
    check("R1 latest_bc after reset", latest_bc, 0);
  endtask

  task automatic t_basic;
    logic [23:0] bc;
    token = 1'b1; rdy = 1'b1;
    step(2);
    pulse_trig(bc);
    check("R2 read low after trigger", read, 0);
    check("R2 req_id advanced", req_id, 1);
    check("R8 latest_id advanced", latest_id, 1);
    check("R9 latest_bc stamp", latest_bc, bc);
    step(2);
    check("R3 read low before delay", read, 0);
    step(1);
    check("R3 read rises third edge", read, 1);
    step(6);
    check("R5 read held with token", read, 1);
    check("R10 req_bc of served trigger", req_bc, bc);
    token = 1'b0;
    step(1);
    check("R7 back to idle", read, 0);
    token = 1'b1;
    step(5);
    check("R7 token alone no restart", read, 0);
    check("R7 req_id unchanged", req_id, 1);
  endtask

  task automatic t_backpressure;
    logic [23:0] bc;
    token = 1'b1; rdy = 1'b0;
    pulse_trig(bc);
    step(6);
    check("R11 held while fifo not ready", read, 0);
    rdy = 1'b1;
    step(1);
    check("R3 read rises once ready", read, 1);
    rdy = 1'b0; token = 1'b0;
    step(5);
    check("R4 read start ignores token", read, 1);
    rdy = 1'b1;
    step(1);
    check("R4 moves to read phase", read, 1);
    step(1);
    check("R7 idle after token drop", read, 0);
    check("R2 req_id tracks", req_id, 2);
  endtask

  task automatic t_pending;
    logic [23:0] bca, bcb;
    token = 1'b1; rdy = 1'b1;
    pulse_trig(bca);
    step(6);
    check("R5 in read phase", read, 1);
    pulse_trig(bcb);
    check("R8 latest during read", latest_id, 4);
    check("R5 req_id stable during read", req_id, 3);
    check("R5 read stays high", read, 1);
    check("R9 second stamp", latest_bc, bcb);
    token = 1'b0;
    step(1);
    check("R6 read drops", read, 0);
    check("R6 req_id steps", req_id, 4);
    token = 1'b1;
    step(2);
    check("R6 read low during delay", read, 0);
    step(1);
    check("R6 read rises again", read, 1);
    check("R10 req_bc follows new id", req_bc, bcb);
    step(3);
    token = 1'b0;
    step(1);
    check("R7 idle after second read", read, 0);
  endtask

  task automatic t_wrap;
    logic [23:0] bc;
    token = 1'b0; rdy = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      bc = cyc;
      trig = 1'b1;
      step(1);
      check("R8 latest_id increments", latest_id, (4 + k) % 16);
    end
    trig = 1'b0;
    check("R9 stamp of last trigger", latest_bc, bc);
    step(8);
    check("R3 no read without token", read, 0);
    check("R2 req_id advanced once", req_id, 5);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_pending();
    t_wrap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule